// File: doc/BRIEF.md
# Cycle-Steal DMA Request Controller

This block serves one DMA channel that borrows the system bus one transfer at a time. An external device holds a request line high while it wants service. The controller samples that level, takes a bus slot away from the processor, and pulls an active-low acknowledge strobe low during the transfer cycle. After each transfer it hands the bus back to the processor for at least one cycle. Each bus cycle is one clock.

Two transfer shapes are supported, and the shape is chosen per transfer. In single-address shape, one DMA cycle runs with the acknowledge asserted. In dual-address shape, a DMA read cycle with the acknowledge asserted is followed by a DMA write cycle. A transfer budget is loaded by an arm strobe. It counts down once per completed transfer. When it runs out, a done flag rises and further requests are ignored until the controller is armed again.

The request line is sampled on a schedule. While the controller is hunting, it samples in every state. Once a request has been taken, the line is next looked at only in the state that drives the acknowledge. If the line is high there, a follow-on transfer is queued. If it is low, the controller goes back to hunting in every state. The request passes through a configurable synchronizer (`SYNC_STAGES` flops, default 2) before any of this logic sees it.

Top module: `dma_cs_ctrl`

## Requirements
- R1: While reset is asserted and right after it, ack_n_o is 1, grant_o is 0, cyc_o is 0 (processor owns the bus), count_o is 0 and done_o is 0.
- R2: The request is level-sensitive. When the controller is hunting and armed, a synchronized request seen high in a processor state makes the next state a DMA cycle.
- R3: ack_n_o is 0 only in the first DMA cycle of a transfer: the single cycle (cyc_o=1) or the read cycle (cyc_o=2). It is 1 in every other state.
- R4: In dual-address shape, a transfer is a read cycle (cyc_o=2) followed directly by a write cycle (cyc_o=3). grant_o is 1 in both cycles.
- R5: Every transfer is followed by at least one processor cycle (cyc_o=0, grant_o=0) before the next transfer starts.
- R6: A request seen high in the acknowledge state queues the next transfer. That transfer starts after exactly one processor cycle, whatever the line does in between.
- R7: A request seen low in the acknowledge state makes the controller sample in every later state, including a write cycle, until it sees the request high.
- R8: The dual_i input is used only in the cycle that launches a transfer. Changing it during a transfer has no effect on that transfer.
- R9: count_o drops by one at the end of each completed transfer: after the single cycle, or after the write cycle.
- R10: When count_o reaches 0 through a transfer, done_o becomes 1. While the count is 0, no transfer starts, whatever the request does.
- R11: arm_i is honoured only in a processor state. It loads count_i into count_o, clears any queued request, restarts hunting, and sets done_o to (count_i==0). In a DMA state it has no effect. An arm in a processor state wins over a launch in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Level request from the device, active high |
| dual_i | input | 1 | 1 selects dual-address shape for the next transfer |
| arm_i | input | 1 | Load the transfer budget |
| count_i | input | CNT_W | Transfer budget loaded by arm_i |
| ack_n_o | output | 1 | Active-low acknowledge to the device |
| grant_o | output | 1 | 1 while the DMA side owns the bus |
| cyc_o | output | 2 | Current bus cycle: 0 processor, 1 single, 2 read, 3 write |
| count_o | output | CNT_W | Transfers left |
| done_o | output | 1 | Budget used up |

## Verification
The bench targets the sampling schedule. It drops the request exactly in the acknowledge state and raises it again only during the write cycle. A design that skips the hunt in non-acknowledge states would then stall. A design that samples too eagerly would start transfers back to back with no processor cycle between them.

It also holds the request high across the end of the budget. A design that failed to block on a zero count would keep granting the bus. The dual_i input is toggled every cycle during transfers, which exposes a write cycle that was dropped or inserted because the mode was not latched. Arm strobes land inside DMA cycles and in the same cycle as a launch, so a controller that reloaded mid-transfer, or let the launch win, would show a wrong count or an extra transfer.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;
  // Bus-cycle kinds; the encoding is visible on cyc_o.
  typedef enum logic [1:0] {
    CYC_CPU    = 2'd0,
    CYC_SINGLE = 2'd1,
    CYC_READ   = 2'd2,
    CYC_WRITE  = 2'd3
  } cyc_e;
endpackage

// File: rtl/dma_cs_reqsync.sv
module dma_cs_reqsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic req_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign req_o = req_i;
    end else begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '0;
        end else begin
          sh_q[0] <= req_i;
          for (int i = 1; i < STAGES; i++) begin
            sh_q[i] <= sh_q[i-1];
          end
        end
      end
      assign req_o = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dma_cs_sampler.sv
// Decides when the request line is looked at and remembers a queued hit.
module dma_cs_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ack_state_i,
  input  logic launch_i,
  input  logic arm_i,
  input  logic active_i,
  output logic pend_o,
  output logic hunt_o
);
  logic pend_q, pend_d;
  logic hunt_q, hunt_d;

  always_comb begin
    pend_d = pend_q;
    hunt_d = hunt_q;
    if (arm_i) begin
      pend_d = 1'b0;
      hunt_d = 1'b1;
    end else if (launch_i) begin
      pend_d = 1'b0;
      hunt_d = 1'b0;
    end else if (ack_state_i) begin
      pend_d = req_i;
      hunt_d = !req_i;
    end else if (hunt_q && req_i && active_i) begin
      pend_d = 1'b1;
      hunt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hunt_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      hunt_q <= hunt_d;
    end
  end

  assign pend_o = pend_q;
  assign hunt_o = hunt_q;
endmodule

// File: rtl/dma_cs_counter.sv
module dma_cs_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  assign active_o = (cnt_q != '0);
  assign cnt_en   = load_i || (dec_i && active_o);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (load_i) begin
      cnt_d  = load_val_i;
      done_d = (load_val_i == '0);
    end else if (dec_i && active_o) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign count_o = cnt_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dma_cs_fsm.sv
module dma_cs_fsm
  import dma_cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic pend_i,
  input  logic hunt_i,
  input  logic active_i,
  input  logic arm_ok_i,
  input  logic dual_i,
  output cyc_e state_o,
  output logic launch_o
);
  cyc_e st_q, st_d;

  assign launch_o = (st_q == CYC_CPU) && active_i && !arm_ok_i &&
                    (pend_i || (hunt_i && req_i));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CYC_CPU:    if (launch_o) st_d = dual_i ? CYC_READ : CYC_SINGLE;
      CYC_SINGLE: st_d = CYC_CPU;
      CYC_READ:   st_d = CYC_WRITE;
      CYC_WRITE:  st_d = CYC_CPU;
      default:    st_d = CYC_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CYC_CPU;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/dma_cs_ctrl.sv
module dma_cs_ctrl
  import dma_cs_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             dual_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             ack_n_o,
  output logic             grant_o,
  output logic [1:0]       cyc_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  logic req_s, pend, hunt, active, launch;
  logic arm_ok, ack_state, complete;
  cyc_e st;

  assign arm_ok    = arm_i && (st == CYC_CPU);
  assign ack_state = (st == CYC_SINGLE) || (st == CYC_READ);
  assign complete  = (st == CYC_SINGLE) || (st == CYC_WRITE);

  dma_cs_reqsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_o(req_s)
  );

  dma_cs_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .req_i(req_s), .ack_state_i(ack_state),
    .launch_i(launch), .arm_i(arm_ok), .active_i(active),
    .pend_o(pend), .hunt_o(hunt)
  );

  dma_cs_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(arm_ok), .load_val_i(count_i),
    .dec_i(complete), .count_o(count_o), .done_o(done_o), .active_o(active)
  );

  dma_cs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_s), .pend_i(pend), .hunt_i(hunt),
    .active_i(active), .arm_ok_i(arm_ok), .dual_i(dual_i),
    .state_o(st), .launch_o(launch)
  );

  assign ack_n_o = !ack_state;
  assign grant_o = (st != CYC_CPU);
  assign cyc_o   = st;
endmodule

// File: rtl/dma_cs_chk.sv
module dma_cs_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_n_o,
  input logic             grant_o,
  input logic [1:0]       cyc_o,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o
);
  AST_ACK_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |-> (grant_o && (cyc_o == 2'd1 || cyc_o == 2'd2))); // R3

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_o == 2'd2) |=> (cyc_o == 2'd3 && grant_o && ack_n_o)); // R4

  AST_CPU_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_o == 2'd1 || cyc_o == 2'd3) |=> (cyc_o == 2'd0 && !grant_o)); // R5

  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_o == 2'd1 || cyc_o == 2'd3) |=> (count_o == $past(count_o) - CNT_W'(1))); // R9

  AST_DONE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!grant_o && count_o == '0)); // R10
endmodule

bind dma_cs_ctrl dma_cs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_n_o(ack_n_o), .grant_o(grant_o),
  .cyc_o(cyc_o), .count_o(count_o), .done_o(done_o)
);

// File: tb/dma_cs_ctrl_tb.sv
module dma_cs_ctrl_tb;
  localparam int CW   = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req, dual, arm;
  logic [CW-1:0] cnt;
  logic ack_n, grant, done;
  logic [1:0] cyc;
  logic [CW-1:0] count;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_cs_ctrl #(.CNT_W(CW), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .dual_i(dual), .arm_i(arm),
    .count_i(cnt), .ack_n_o(ack_n), .grant_o(grant), .cyc_o(cyc),
    .count_o(count), .done_o(done)
  );

  // Behavioural reference: bus-slot schedule per requirement text.
  int m_slot;        // 0 cpu, 1 single, 2 read, 3 write
  bit m_queued, m_hunting, m_done;
  int m_left;
  bit rq[$];

  task automatic model_reset();
    m_slot = 0; m_queued = 0; m_hunting = 1; m_done = 0; m_left = 0;
    rq.delete();
    for (int i = 0; i < SYNC; i++) rq.push_back(1'b0);
  endtask

  task automatic model_step();
    bit seen, arm_taken, start, finish_xfer;
    int nxt;
    if (SYNC == 0) seen = req;
    else begin seen = rq.pop_front(); rq.push_back(req); end
    arm_taken   = arm && (m_slot == 0);
    finish_xfer = (m_slot == 1) || (m_slot == 3);
    start = (m_slot == 0) && (m_left > 0) && !arm_taken &&
            (m_queued || (m_hunting && seen));
    case (m_slot)
      0: nxt = start ? (dual ? 2 : 1) : 0;
      2: nxt = 3;
      default: nxt = 0;
    endcase
    if (arm_taken) begin m_queued = 0; m_hunting = 1; end
    else if (start) begin m_queued = 0; m_hunting = 0; end
    else if (m_slot == 1 || m_slot == 2) begin m_queued = seen; m_hunting = !seen; end
    else if (m_hunting && seen && m_left > 0) begin m_queued = 1; m_hunting = 0; end
    if (arm_taken) begin m_left = int'(cnt); m_done = (cnt == 0); end
    else if (finish_xfer && m_left > 0) begin
      m_left--;
      if (m_left == 0) m_done = 1;
    end
    m_slot = nxt;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, {31'd0, ack_n}, {31'd0, !(m_slot == 1 || m_slot == 2)}, "ack_n");
    check(tag, {31'd0, grant}, {31'd0, m_slot != 0}, "grant");
    check(tag, {30'd0, cyc}, m_slot, "cyc");
    check(tag, {24'd0, count}, m_left, "count");
    check(tag, {31'd0, done}, {31'd0, m_done}, "done");
  endtask

  task automatic tick(input logic r, input logic d, input logic a, input logic [CW-1:0] c, input string tag);
    @(negedge clk);
    model_step();
    compare(tag);
    req = r; dual = d; arm = a; cnt = c;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  int grants;

  initial begin
    rst_n = 0; req = 0; dual = 0; arm = 0; cnt = '0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    tick(0, 0, 0, 0, "R1");
    // R11: arm a budget of 6
    tick(0, 0, 1, 8'd6, "R11");
    tick(0, 0, 0, 0, "R11");
    check("R11", {24'd0, count}, 32'd6, "count after arm");
    // R2 R6: held request, back-to-back single transfers
    for (int i = 0; i < 14; i++) tick(1, 0, 0, 0, "R6");
    // R10: budget exhausted, request held, no grant
    grants = 0;
    for (int i = 0; i < 10; i++) begin tick(1, 0, 0, 0, "R10"); grants += grant; end
    check("R10", grants, 0, "grants while exhausted");
    check("R10", {31'd0, done}, 1, "done flag");
    // re-arm, dual shape, single pulse
    tick(0, 1, 1, 8'd40, "R11");
    tick(1, 1, 0, 0, "R4");
    for (int i = 0; i < 8; i++) tick(0, 1, 0, 0, "R4");
    // R7: request low in the ack state, high only in the write cycle
    for (int i = 0; i < 30; i++) tick((i % 3) == 2, 1, 0, 0, "R7");
    for (int i = 0; i < 30; i++) tick((i % 4) == 1, 1, 0, 0, "R7");
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 0, "R5");
    // R8: mode toggles every cycle
    for (int i = 0; i < 24; i++) tick(1, i[0], 0, 0, "R8");
    // R11: arm pulses landing in DMA states and in launch cycles
    for (int i = 0; i < 20; i++) tick(1, 1, (i % 5) == 0, 8'd9, "R11");
    tick(0, 0, 0, 0, "R11");
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 0, "R11");
    // R11: arm with zero budget gives done
    tick(0, 0, 1, 8'd0, "R11");
    tick(0, 0, 0, 0, "R11");
    check("R11", {31'd0, done}, 1, "done after zero arm");
    // R2 R3 R9: short single-shape budget run to the end
    tick(0, 0, 1, 8'd3, "R9");
    tick(1, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) tick(0, 0, 0, 0, "R3");
    for (int i = 0; i < 16; i++) tick(i[1], 0, 0, 0, "R9");
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, "R10");
    check("R9", {24'd0, count}, 32'd0, "count at end");
    finished = 1;
    summary();
    $finish;
  end
endmodule